// File: doc/BRIEF.md
# Bit-Serial Switch Register Access Master

This block gives a host on the system clock access to the 16-bit configuration registers of a switch device over a three-wire serial link. The link has a chip select, a serial clock and one bidirectional data line, and follows serial EEPROM conventions. The host raises a one-cycle request that carries a read/write flag, a register address and write data. The block then runs the whole serial transaction and ends it with a one-cycle done pulse. For a read, the register value is presented together with that pulse.

Writes and reads use different frames. A write is a short frame with chip select high, followed by two trailing clock pulses. A read keeps chip select low. It sends a long preamble and a command, releases the data line and clocks in a 32-bit word that holds a pair of registers. The block returns the half of that word selected by the low address bit. Two parameters set the serial clock timing in system-clock cycles: the half-period and the data setup time.

Top module: `sreg_serial_master`

## Requirements
- R1: After reset, and whenever no transaction is in progress, `cs_o`, `sclk_o`, `sd_oe_o`, `busy_o` and `done_o` are all low.
- R2: A write sends 27 bits MSB first while `cs_o` is high, sampled by the slave on rising `sclk_o`: bit 26 = 1, bits 25:24 = 01, bits 23:16 = `addr_i[7:0]`, bits 15:0 = `wdata_i`.
- R3: After the last write bit, the clock stays low for one half-period and then `cs_o` falls. Exactly two more clock pulses follow with `cs_o` low, so a write has 29 rising edges in total before `done_o`.
- R4: A read sends 46 bits MSB first with `cs_o` low for the whole transaction: 32 ones, then 0110000, then `addr_i[6:0]`.
- R5: After the read command, `sd_oe_o` goes low. The block gives two idle pulses, clocks in 32 bits MSB first (each sampled through a two-flop synchronizer at the end of the low phase before a rising edge), then gives two more pulses, for 82 rising edges in total.
- R6: With `addr_i[0]` = 1, `rdata_o` holds the first 16 bits received. With `addr_i[0]` = 0, it holds the last 16 bits received.
- R7: Each high or low phase of `sclk_o` lasts at least HALF_CYC cycles. The first low phase after acceptance counts as well. While driven, `sd_o` changes only while `sclk_o` is low and is stable for at least SETUP_CYC cycles before each rising edge.
- R8: `busy_o` rises on the cycle after an accepted request and stays high through the one-cycle `done_o` pulse. A request presented while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transaction request, sampled when idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register address (reads use bits 6:0) |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result, valid with done_o |
| cs_o | output | 1 | Serial chip select |
| sclk_o | output | 1 | Serial clock |
| sd_o | output | 1 | Serial data out |
| sd_oe_o | output | 1 | Serial data output enable |
| sd_i | input | 1 | Serial data in |

## Verification
The hardest case to reach is the read turnaround. The responder has to start driving the line on the falling edge that follows the second idle pulse after release, and the block must capture that bit through its synchronizer at the right phase. A one-bit slip there moves the whole word and swaps which register lands in `rdata_o`. To reach it, the bench's responder counts rising edges from the moment the output enable drops. Its device registers are pre-loaded so that each odd/even pair differs, and the bench reads both addresses of several pairs, including one just written. Any error in the turnaround, the bit order or the half selection then shows up as a wrong value.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int REG_W      = 16;
  localparam int ADDR_W     = 8;
  localparam int RD_ADDR_W  = 7;
  localparam int RD_BITS    = 46;
  localparam int WR_BITS    = 27;
  localparam int RX_BITS    = 2 * REG_W;
  localparam int PAD_PULSES = 2;
  localparam int FRAME_W    = RD_BITS;
  localparam int CNT_W      = $clog2(FRAME_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_LEAD, ST_TX_LO, ST_TX_HI, ST_TX_END,
    ST_PAD_HI, ST_PAD_LO, ST_RX_LO, ST_RX_HI, ST_RX_END, ST_DONE
  } sreg_state_e;

  // Read command: preamble of ones, start, opcode, turn bits, address
  function automatic logic [FRAME_W-1:0] rd_frame(input logic [RD_ADDR_W-1:0] a);
    return {32'hFFFF_FFFF, 2'b01, 2'b10, 1'b0, 2'b00, a};
  endfunction

  // Write command, left aligned in the shift register
  function automatic logic [FRAME_W-1:0] wr_frame(input logic [ADDR_W-1:0] a,
                                                  input logic [REG_W-1:0] d);
    return {1'b1, 2'b01, a, d, {(FRAME_W-WR_BITS){1'b0}}};
  endfunction
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/sreg_phase_timer.sv
module sreg_phase_timer #(
  parameter int HALF_CYC  = 150,
  parameter int SETUP_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o,
  output logic upd_o
);
  localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] UPD_V  = CW'(HALF_CYC - 1 - SETUP_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt <= '0;
    else if (!run_i)     cnt <= '0;
    else if (cnt == LAST_V) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign last_o = run_i && (cnt == LAST_V);
  // data moves SETUP_CYC cycles before the phase ends
  assign upd_o  = run_i && (cnt == UPD_V);
endmodule

// File: rtl/sreg_serial_master.sv
module sreg_serial_master
  import sreg_pkg::*;
#(
  parameter int HALF_CYC  = 150,
  parameter int SETUP_CYC = 50
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        wr_i,
  input  logic [7:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        cs_o,
  output logic        sclk_o,
  output logic        sd_o,
  output logic        sd_oe_o,
  input  logic        sd_i
);
  sreg_state_e         state_q;
  logic [FRAME_W-1:0]  sh_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [RX_BITS-1:0]  rx_q;
  logic [REG_W-1:0]    rdata_q;
  logic                wr_q, odd_q, post_rx_q, dout_q;
  logic                din_s, last, upd, run;

  assign run = (state_q != ST_IDLE) && (state_q != ST_DONE);

  sreg_phase_timer #(.HALF_CYC(HALF_CYC), .SETUP_CYC(SETUP_CYC)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .last_o(last), .upd_o(upd)
  );

  sreg_sync #(.STAGES(2)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sd_i), .q_o(din_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      rx_q      <= '0;
      rdata_q   <= '0;
      wr_q      <= 1'b0;
      odd_q     <= 1'b0;
      post_rx_q <= 1'b0;
      dout_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q   <= ST_LEAD;
          wr_q      <= wr_i;
          odd_q     <= addr_i[0];
          post_rx_q <= 1'b0;
          sh_q      <= wr_i ? wr_frame(addr_i, wdata_i) : rd_frame(addr_i[RD_ADDR_W-1:0]);
          cnt_q     <= wr_i ? CNT_W'(WR_BITS) : CNT_W'(RD_BITS);
        end
        ST_LEAD: if (last) state_q <= ST_TX_LO;
        ST_TX_LO: begin
          if (upd) begin
            dout_q <= sh_q[FRAME_W-1];
            sh_q   <= sh_q << 1;
          end
          if (last) state_q <= ST_TX_HI;
        end
        ST_TX_HI: if (last) begin
          if (cnt_q == CNT_W'(1)) begin
            state_q <= ST_TX_END;
            cnt_q   <= CNT_W'(PAD_PULSES);
          end else begin
            state_q <= ST_TX_LO;
            cnt_q   <= cnt_q - 1'b1;
          end
        end
        ST_TX_END: if (last) state_q <= ST_PAD_HI;
        ST_PAD_HI: if (last) state_q <= ST_PAD_LO;
        ST_PAD_LO: if (last) begin
          if (cnt_q != CNT_W'(1)) begin
            state_q <= ST_PAD_HI;
            cnt_q   <= cnt_q - 1'b1;
          end else if (!wr_q && !post_rx_q) begin
            state_q <= ST_RX_LO;
            cnt_q   <= CNT_W'(RX_BITS);
          end else begin
            state_q <= ST_DONE;
            dout_q  <= 1'b0;
          end
        end
        ST_RX_LO: if (last) begin
          rx_q    <= {rx_q[RX_BITS-2:0], din_s};
          state_q <= ST_RX_HI;
        end
        ST_RX_HI: if (last) begin
          if (cnt_q == CNT_W'(1)) state_q <= ST_RX_END;
          else begin
            state_q <= ST_RX_LO;
            cnt_q   <= cnt_q - 1'b1;
          end
        end
        ST_RX_END: if (last) begin
          state_q   <= ST_PAD_HI;
          cnt_q     <= CNT_W'(PAD_PULSES);
          post_rx_q <= 1'b1;
          rdata_q   <= odd_q ? rx_q[RX_BITS-1:REG_W] : rx_q[REG_W-1:0];
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic in_tx;
  assign in_tx = (state_q == ST_LEAD) || (state_q == ST_TX_LO) ||
                 (state_q == ST_TX_HI) || (state_q == ST_TX_END);

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);
  assign rdata_o = rdata_q;
  assign cs_o    = wr_q && in_tx;
  assign sclk_o  = (state_q == ST_TX_HI) || (state_q == ST_PAD_HI) || (state_q == ST_RX_HI);
  // writes keep driving through the trailing pulses; reads release after the command
  assign sd_oe_o = in_tx || (wr_q && ((state_q == ST_PAD_HI) || (state_q == ST_PAD_LO)));
  assign sd_o    = dout_q;
endmodule

// File: rtl/sreg_checker.sv
module sreg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic wr_i,
  input logic busy_o,
  input logic done_o,
  input logic cs_o,
  input logic sclk_o,
  input logic sd_o,
  input logic sd_oe_o
);
  logic       wr_l, sclk_p;
  logic [7:0] rises;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_l   <= 1'b0;
      sclk_p <= 1'b0;
      rises  <= '0;
    end else begin
      sclk_p <= sclk_o;
      if (req_i && !busy_o) begin
        wr_l  <= wr_i;
        rises <= '0;
      end else if (sclk_o && !sclk_p) begin
        rises <= rises + 1'b1;
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!cs_o && !sclk_o && !sd_oe_o && !done_o));

  a_r4_read_cs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !wr_l) |-> !cs_o);

  a_r7_setup_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_oe_o && $rose(sclk_o)) |-> $stable(sd_o));

  a_r7_change_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_oe_o && $past(sd_oe_o) && !$stable(sd_o)) |-> !sclk_o);

  a_r8_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  a_r3_write_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && wr_l) |-> (rises == 8'd29));

  a_r5_read_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !wr_l) |-> (rises == 8'd82));
endmodule

bind sreg_serial_master sreg_checker i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i),
  .busy_o(busy_o), .done_o(done_o), .cs_o(cs_o), .sclk_o(sclk_o),
  .sd_o(sd_o), .sd_oe_o(sd_oe_o)
);

// File: tb/test_sreg_serial_master.sv
module test_sreg_serial_master;
  localparam int HALF  = 4;
  localparam int SETUP = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0, wr_i = 1'b0, sd_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic busy_o, done_o, cs_o, sclk_o, sd_o, sd_oe_o;
  logic [15:0] rdata_o;

  sreg_serial_master #(.HALF_CYC(HALF), .SETUP_CYC(SETUP)) i_sreg_serial_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .cs_o(cs_o), .sclk_o(sclk_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o), .sd_i(sd_i)
  );

  always #2 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct { bit wr; logic [7:0] addr; logic [15:0] val; } item_t;
  item_t sbq[$];
  logic [15:0] dev_mem [256];
  logic [15:0] ref_mem [256];

  logic [45:0] fr = '0;
  logic [31:0] rd_word = '0;
  int  nb = 0, tot_rises = 0, rd_rises = 0, rd_bit = 0;
  int  lo_run = 0, hi_run = 0, since = 0;
  int  half_bad = 0, setup_bad = 0, cs_bad = 0, oe_bad = 0;
  bit  cur_wr = 1'b0, rd_active = 1'b0;
  logic sclk_p = 1'b0, cs_p = 1'b0, oe_p = 1'b0, sd_p = 1'b0;

  // responder and scoreboard monitor, sampled away from the active edge
  always @(negedge clk_i) begin
    logic rise, fall;
    rise = sclk_o && !sclk_p;
    fall = !sclk_o && sclk_p;
    if (sd_o !== sd_p) since = 0; else since++;
    if (busy_o && !cur_wr && cs_o) cs_bad++;
    if (rd_active && sd_oe_o) oe_bad++;
    if (cs_p && !cs_o) begin
      chk(nb == 27, "R2 write bit count", nb, 27);
      chk(fr[26:24] == 3'b101, "R2 write start/opcode", fr[26:24], 3'b101);
      dev_mem[fr[23:16]] = fr[15:0];
      nb = 0;
    end
    if (oe_p && !sd_oe_o && !cur_wr && !rd_active) begin
      logic [6:0] a;
      chk(nb == 46, "R4 read bit count", nb, 46);
      chk(fr[45:14] == 32'hFFFF_FFFF, "R4 read preamble", fr[45:14], 32'hFFFF_FFFF);
      chk(fr[13:7] == 7'b0110000, "R4 read command", fr[13:7], 7'b0110000);
      a = fr[6:0];
      rd_word = {dev_mem[{1'b0, a[6:1], 1'b1}], dev_mem[{1'b0, a[6:1], 1'b0}]};
      rd_active = 1'b1; rd_rises = 0; rd_bit = 0; nb = 0;
    end
    if (rise) begin
      tot_rises++;
      if (sd_oe_o && (!cur_wr || cs_o)) begin
        fr = {fr[44:0], sd_o};
        nb++;
        if (since < SETUP) setup_bad++;
      end
      if (rd_active) rd_rises++;
      if (lo_run < HALF) half_bad++;
      lo_run = 0;
    end
    if (fall) begin
      if (hi_run < HALF) half_bad++;
      hi_run = 0;
      if (rd_active && rd_rises >= 2 && rd_bit < 32) begin
        sd_i <= rd_word[31-rd_bit];
        rd_bit++;
      end
    end
    if (sclk_o) hi_run++;
    else if (busy_o) lo_run++;
    else lo_run = 0;
    if (done_o) begin
      chk(busy_o, "R8 busy high with done", busy_o, 1);
      if (sbq.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
      else begin
        item_t it;
        it = sbq.pop_front();
        if (it.wr) begin
          chk(dev_mem[it.addr] == it.val, "R2 write landed", dev_mem[it.addr], it.val);
          chk(tot_rises == 29, "R3 write rising edges", tot_rises, 29);
        end else begin
          chk(rdata_o == it.val, "R6 read data half", rdata_o, it.val);
          chk(tot_rises == 82, "R5 read rising edges", tot_rises, 82);
          chk(rd_bit == 32, "R5 read bits driven", rd_bit, 32);
        end
      end
      rd_active = 1'b0;
    end
    sclk_p = sclk_o; cs_p = cs_o; oe_p = sd_oe_o; sd_p = sd_o;
  end

  task automatic op(input bit w, input logic [7:0] a, input logic [15:0] d);
    item_t it;
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    it.wr = w; it.addr = w ? a : {1'b0, a[6:0]};
    it.val = w ? d : ref_mem[{1'b0, a[6:0]}];
    if (w) ref_mem[a] = d;
    sbq.push_back(it);
    cur_wr = w; tot_rises = 0;
    req_i = 1'b1; wr_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    chk(half_bad == 0, "R7 half period", half_bad, 0);
    chk(setup_bad == 0, "R7 data setup", setup_bad, 0);
    chk(cs_bad == 0, "R4 cs low in read", cs_bad, 0);
    chk(oe_bad == 0, "R5 line released", oe_bad, 0);
    chk(sbq.size() == 0, "R8 pending items", sbq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      dev_mem[i] = 16'h3C00 ^ 16'(i * 16'h0107);
      ref_mem[i] = dev_mem[i];
    end
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk({cs_o, sclk_o, sd_oe_o, busy_o, done_o} == 5'b0, "R1 reset quiet",
        {cs_o, sclk_o, sd_oe_o, busy_o, done_o}, 0);

    op(1'b1, 8'h05, 16'h1234);
    op(1'b1, 8'h0A, 16'hBEEF);
    op(1'b1, 8'hC3, 16'h5A5A);
    op(1'b0, 8'h05, 16'h0);   // odd: first half
    op(1'b0, 8'h04, 16'h0);   // even: last half
    op(1'b0, 8'h0A, 16'h0);
    op(1'b0, 8'h0B, 16'h0);
    op(1'b0, 8'h00, 16'h0);
    op(1'b1, 8'h7F, 16'hFFFF);
    op(1'b0, 8'h7F, 16'h0);
    op(1'b0, 8'h7E, 16'h0);
    op(1'b0, 8'h85, 16'h0);   // R4 only the low seven address bits go out

    // R8 requests while busy are ignored
    op(1'b1, 8'h21, 16'h0F0F);
    for (int k = 0; k < 6; k++) begin
      repeat (7) @(negedge clk_i);
      req_i = 1'b1; wr_i = 1'b1; addr_i = 8'hF0; wdata_i = 16'hDEAD;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    wait_idle();
    chk(dev_mem[8'hF0] == ref_mem[8'hF0], "R8 busy request ignored", dev_mem[8'hF0], ref_mem[8'hF0]);
    op(1'b0, 8'h21, 16'h0);
    wait_idle();
    // R1 idle after traffic
    chk({cs_o, sclk_o, sd_oe_o, busy_o} == 4'b0, "R1 idle quiet", {cs_o, sclk_o, sd_oe_o, busy_o}, 0);
    finish_run();
  end
endmodule